// File: doc/BRIEF.md
# Frequency-Change Watchdog and Recovery Controller

This block guards software-initiated changes of a clock synthesizer's output frequency. It holds the configuration fields involved: a 4-bit timeout in seconds, a revert-policy bit, the software frequency code, the source select between the hardware-strapped code and the software code, and the enable of the programmable ratio mode. It receives decoded register-write strobes with their data from a serial configuration front end. The PLL, the dividers and the bus itself are outside the block.

A frequency request is either a write of the software frequency code or a write of 1 to the programmable-mode enable. When the timeout field is nonzero at that moment, a countdown of that many seconds starts. Firmware that still runs on the new frequency confirms it by writing zero to the timeout field. If the countdown runs out first, the block sets an alarm flag. It then reselects the frequency source according to the policy bit, turns off the programmable mode, and pulls the open-drain system reset line low for a fixed pulse width. An internal prescaler derives the one-second step and the pulse width from the core clock, and both are set by parameters.

Top module: `wdt_freq_guard`

## Requirements
- R1: After reset the pull-down output is 0, the timeout field, alarm, policy bit, source select and programmable enable all read 0, and the effective code equals the strap code.
- R2: Field writes take effect on the next clock. The effective frequency code is the software code when the source select is 1 and the strap code when it is 0.
- R3: A request made while the timeout field holds T (1 to 15) expires exactly T*CLKS_PER_SEC clock edges after the edge that captured the request. The pull-down output rises on that edge.
- R4: A request made while the timeout field is 0 never produces a reset pulse.
- R5: Writing 0 to the timeout field before expiry cancels the countdown. No pulse follows, and the software code and source select keep their values.
- R6: A new request while the countdown runs restarts it from the full programmed timeout.
- R7: On expiry the alarm flag becomes 1, and the pull-down output stays 1 for exactly PULSE_CLKS cycles. It then returns to 0 with the watchdog disarmed.
- R8: On expiry a policy bit of 0 clears the source select, so the strap code is used. A policy bit of 1 sets the source select to 1, so the last software code is kept. In both cases the programmable enable is cleared.
- R9: Writing 0 to the timeout field clears the alarm flag. A nonzero write leaves the alarm flag unchanged and does not restart a running countdown.
- R10: Requests that arrive during the reset pulse are ignored and arm nothing.
- R11: Writing 0 to the programmable enable is not a frequency request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strap_code_i | input | 5 | Hardware-latched frequency code |
| tmo_we_i | input | 1 | Timeout field write strobe |
| tmo_wdata_i | input | 4 | Timeout value in seconds, 0 disables |
| revert_we_i | input | 1 | Policy bit write strobe |
| revert_wdata_i | input | 1 | Policy: 0 strap code, 1 last software code |
| code_we_i | input | 1 | Software code write strobe (a request) |
| code_wdata_i | input | 5 | Software frequency code |
| src_we_i | input | 1 | Source select write strobe |
| src_wdata_i | input | 1 | Source: 1 software code, 0 strap code |
| prog_we_i | input | 1 | Programmable-mode enable write strobe |
| prog_wdata_i | input | 1 | Programmable enable value (1 is a request) |
| freq_code_o | output | 5 | Effective frequency code |
| src_sw_o | output | 1 | Current source select |
| prog_en_o | output | 1 | Programmable-mode enable |
| tmo_o | output | 4 | Timeout field |
| revert_o | output | 1 | Policy bit |
| alarm_o | output | 1 | Watchdog alarm flag |
| sys_rst_pull_o | output | 1 | 1 pulls the open-drain reset line low |

## Verification
The bench builds the block with CLKS_PER_SEC = 20 and PULSE_CLKS = 7. A 15-second timeout then spans 300 cycles instead of seconds of core clock. This makes it possible to check the exact expiry edge for every timeout tried and the full pulse width from rise to fall. It also allows long idle windows after cancellation, after a zero timeout and after an ignored request. Random timeouts, policy bits, codes and request kinds are mixed with directed restart, cancel and in-pulse cases.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int unsigned CODE_W = 5;
  localparam int unsigned TMO_W  = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_PULSE} wd_state_e;

  typedef struct packed {
    logic [TMO_W-1:0]  tmo;
    logic              revert;
    logic              src_sw;
    logic              prog_en;
    logic [CODE_W-1:0] sw_code;
    logic              alarm;
  } cfg_t;
endpackage

// File: rtl/wdg_cycle_cnt.sv
module wdg_cycle_cnt #(
  parameter int unsigned LIMIT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic last_o
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign last_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (en_i)    cnt_q <= last_o ? '0 : cnt_q + CW'(1);
  end
endmodule

// File: rtl/wdg_cfg_regs.sv
module wdg_cfg_regs
  import wdg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tmo_we_i,
  input  logic [TMO_W-1:0]  tmo_wdata_i,
  input  logic              revert_we_i,
  input  logic              revert_wdata_i,
  input  logic              code_we_i,
  input  logic [CODE_W-1:0] code_wdata_i,
  input  logic              src_we_i,
  input  logic              src_wdata_i,
  input  logic              prog_we_i,
  input  logic              prog_wdata_i,
  input  logic              expire_i,
  output cfg_t              cfg_o
);
  cfg_t cfg_q;

  assign cfg_o = cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else begin
      if (tmo_we_i) begin
        cfg_q.tmo <= tmo_wdata_i;
        if (tmo_wdata_i == '0) cfg_q.alarm <= 1'b0;
      end
      if (revert_we_i) cfg_q.revert  <= revert_wdata_i;
      if (code_we_i)   cfg_q.sw_code <= code_wdata_i;
      if (src_we_i)    cfg_q.src_sw  <= src_wdata_i;
      if (prog_we_i)   cfg_q.prog_en <= prog_wdata_i;
      // expiry overrides same-cycle software writes of the source fields
      if (expire_i) begin
        cfg_q.alarm   <= 1'b1;
        cfg_q.src_sw  <= cfg_q.revert;
        cfg_q.prog_en <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
  import wdg_pkg::*;
#(
  parameter int unsigned CLKS_PER_SEC = 100_000_000,
  parameter int unsigned PULSE_CLKS   = 600_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             cancel_i,
  input  logic [TMO_W-1:0] tmo_i,
  output logic             expire_o,
  output logic             pull_o
);
  wd_state_e        state_q;
  logic [TMO_W-1:0] sec_q;
  logic             arm, sec_last, pulse_last, in_run, in_pulse, final_sec;

  assign in_run    = (state_q == ST_RUN);
  assign in_pulse  = (state_q == ST_PULSE);
  assign arm       = req_i && (tmo_i != '0) && !in_pulse && !cancel_i;
  assign final_sec = (sec_q == TMO_W'(1));
  assign expire_o  = in_run && sec_last && final_sec && !cancel_i && !arm;
  assign pull_o    = in_pulse;

  wdg_cycle_cnt #(.LIMIT(CLKS_PER_SEC)) u_sec_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!in_run || arm),
    .en_i   (in_run),
    .last_o (sec_last)
  );

  wdg_cycle_cnt #(.LIMIT(PULSE_CLKS)) u_pulse_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!in_pulse),
    .en_i   (in_pulse),
    .last_o (pulse_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sec_q   <= '0;
    end else if (cancel_i && in_run) begin
      state_q <= ST_IDLE;
    end else if (arm) begin
      state_q <= ST_RUN;
      sec_q   <= tmo_i;
    end else if (in_run && sec_last) begin
      if (final_sec) state_q <= ST_PULSE;
      else           sec_q   <= sec_q - TMO_W'(1);
    end else if (in_pulse && pulse_last) begin
      state_q <= ST_IDLE;
    end
  end
endmodule

// File: rtl/wdt_freq_guard.sv
module wdt_freq_guard
  import wdg_pkg::*;
#(
  parameter int unsigned CLKS_PER_SEC = 100_000_000,
  parameter int unsigned PULSE_CLKS   = 600_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] strap_code_i,
  input  logic              tmo_we_i,
  input  logic [TMO_W-1:0]  tmo_wdata_i,
  input  logic              revert_we_i,
  input  logic              revert_wdata_i,
  input  logic              code_we_i,
  input  logic [CODE_W-1:0] code_wdata_i,
  input  logic              src_we_i,
  input  logic              src_wdata_i,
  input  logic              prog_we_i,
  input  logic              prog_wdata_i,
  output logic [CODE_W-1:0] freq_code_o,
  output logic              src_sw_o,
  output logic              prog_en_o,
  output logic [TMO_W-1:0]  tmo_o,
  output logic              revert_o,
  output logic              alarm_o,
  output logic              sys_rst_pull_o
);
  cfg_t cfg;
  logic req, cancel, expire;

  assign req    = code_we_i || (prog_we_i && prog_wdata_i);
  assign cancel = tmo_we_i && (tmo_wdata_i == '0);

  wdg_cfg_regs u_regs (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .tmo_we_i       (tmo_we_i),
    .tmo_wdata_i    (tmo_wdata_i),
    .revert_we_i    (revert_we_i),
    .revert_wdata_i (revert_wdata_i),
    .code_we_i      (code_we_i),
    .code_wdata_i   (code_wdata_i),
    .src_we_i       (src_we_i),
    .src_wdata_i    (src_wdata_i),
    .prog_we_i      (prog_we_i),
    .prog_wdata_i   (prog_wdata_i),
    .expire_i       (expire),
    .cfg_o          (cfg)
  );

  wdg_timer #(
    .CLKS_PER_SEC (CLKS_PER_SEC),
    .PULSE_CLKS   (PULSE_CLKS)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req),
    .cancel_i (cancel),
    .tmo_i    (cfg.tmo),
    .expire_o (expire),
    .pull_o   (sys_rst_pull_o)
  );

  assign freq_code_o = cfg.src_sw ? cfg.sw_code : strap_code_i;
  assign src_sw_o    = cfg.src_sw;
  assign prog_en_o   = cfg.prog_en;
  assign tmo_o       = cfg.tmo;
  assign revert_o    = cfg.revert;
  assign alarm_o     = cfg.alarm;
endmodule

// File: rtl/wdg_guard_chk.sv
module wdg_guard_chk
  import wdg_pkg::*;
#(
  parameter int unsigned PULSE_CLKS = 600_000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CODE_W-1:0] strap_code_i,
  input logic              tmo_we_i,
  input logic [TMO_W-1:0]  tmo_wdata_i,
  input logic [CODE_W-1:0] freq_code_o,
  input logic              src_sw_o,
  input logic              prog_en_o,
  input logic [TMO_W-1:0]  tmo_o,
  input logic              revert_o,
  input logic              alarm_o,
  input logic              sys_rst_pull_o
);
  int unsigned run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             run_q <= 0;
    else if (sys_rst_pull_o) run_q <= run_q + 1;
    else                     run_q <= 0;
  end

  a_r7_pulse_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_pull_o |-> run_q < PULSE_CLKS);

  a_r7_pulse_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_pull_o) |-> run_q == PULSE_CLKS);

  a_r7_alarm_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_pull_o) |-> alarm_o);

  a_r8_revert_hw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_pull_o) && !$past(revert_o) |-> !src_sw_o && freq_code_o == strap_code_i);

  a_r8_revert_sw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_pull_o) && $past(revert_o) |-> src_sw_o);

  a_r8_prog_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_pull_o) |-> !prog_en_o);

  a_r3_tmo_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_pull_o) |-> $past(tmo_o) != '0);

  a_r9_alarm_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_we_i && tmo_wdata_i == '0 |=> !alarm_o);
endmodule

bind wdt_freq_guard wdg_guard_chk #(.PULSE_CLKS(PULSE_CLKS)) u_guard_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .strap_code_i   (strap_code_i),
  .tmo_we_i       (tmo_we_i),
  .tmo_wdata_i    (tmo_wdata_i),
  .freq_code_o    (freq_code_o),
  .src_sw_o       (src_sw_o),
  .prog_en_o      (prog_en_o),
  .tmo_o          (tmo_o),
  .revert_o       (revert_o),
  .alarm_o        (alarm_o),
  .sys_rst_pull_o (sys_rst_pull_o)
);

// File: tb/tb_wdt_freq_guard.sv
`timescale 1ns/1ps
module tb_wdt_freq_guard;
  localparam int CPS = 20;
  localparam int PW  = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] strap = 5'd0;
  logic       tmo_we = 0, rev_we = 0, code_we = 0, src_we = 0, prog_we = 0;
  logic [3:0] tmo_wd = '0;
  logic       rev_wd = 0, src_wd = 0, prog_wd = 0;
  logic [4:0] code_wd = '0;
  logic [4:0] freq_code;
  logic       src_sw, prog_en, revert, alarm, pull;
  logic [3:0] tmo;

  int checks = 0;
  int failures = 0;
  int pd_hist = 0;

  always #2 clk = ~clk;

  wdt_freq_guard #(.CLKS_PER_SEC(CPS), .PULSE_CLKS(PW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .strap_code_i(strap),
    .tmo_we_i(tmo_we), .tmo_wdata_i(tmo_wd),
    .revert_we_i(rev_we), .revert_wdata_i(rev_wd),
    .code_we_i(code_we), .code_wdata_i(code_wd),
    .src_we_i(src_we), .src_wdata_i(src_wd),
    .prog_we_i(prog_we), .prog_wdata_i(prog_wd),
    .freq_code_o(freq_code), .src_sw_o(src_sw), .prog_en_o(prog_en),
    .tmo_o(tmo), .revert_o(revert), .alarm_o(alarm), .sys_rst_pull_o(pull)
  );

  always @(posedge clk) if (pull === 1'b1) pd_hist++;

  function automatic int exp_code(input bit src, input int sw, input int st);
    return src ? sw : st;
  endfunction

  function automatic int exp_delay(input int t);
    return t * CPS;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_tmo(input logic [3:0] v);
    tmo_we = 1; tmo_wd = v; @(negedge clk); tmo_we = 0;
  endtask
  task automatic wr_rev(input logic v);
    rev_we = 1; rev_wd = v; @(negedge clk); rev_we = 0;
  endtask
  task automatic wr_code(input logic [4:0] v);
    code_we = 1; code_wd = v; @(negedge clk); code_we = 0;
  endtask
  task automatic wr_src(input logic v);
    src_we = 1; src_wd = v; @(negedge clk); src_we = 0;
  endtask
  task automatic wr_prog(input logic v);
    prog_we = 1; prog_wd = v; @(negedge clk); prog_we = 0;
  endtask

  // called right after the request edge
  task automatic expect_expiry(input int t, input bit rv, input int sw, input string tag);
    wait_n(exp_delay(t) - 1);
    chk({tag, " R3 pull before deadline"}, 32'(pull), 0);
    wait_n(1);
    chk({tag, " R3 pull at deadline"}, 32'(pull), 1);
    chk({tag, " R7 alarm"}, 32'(alarm), 1);
    chk({tag, " R8 source"}, 32'(src_sw), 32'(rv));
    chk({tag, " R8 code"}, 32'(freq_code), exp_code(rv, sw, int'(strap)));
    chk({tag, " R8 prog off"}, 32'(prog_en), 0);
    wait_n(PW - 1);
    chk({tag, " R7 pull last cycle"}, 32'(pull), 1);
    wait_n(1);
    chk({tag, " R7 pull released"}, 32'(pull), 0);
  endtask

  task automatic expect_quiet(input int n, input string tag);
    int h0;
    h0 = pd_hist;
    wait_n(n);
    chk(tag, 32'(pd_hist - h0), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired act=hang exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int h0;
    void'($urandom(32'h5eed_0042));
    strap = 5'd19;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    // R1 reset state
    chk("R1 pull", 32'(pull), 0);
    chk("R1 alarm", 32'(alarm), 0);
    chk("R1 tmo", 32'(tmo), 0);
    chk("R1 revert", 32'(revert), 0);
    chk("R1 src", 32'(src_sw), 0);
    chk("R1 prog", 32'(prog_en), 0);
    chk("R1 code", 32'(freq_code), 19);

    // R2 field writes and code mux
    wr_code(5'd9);
    wr_src(1'b1);
    chk("R2 sw code selected", 32'(freq_code), 9);
    wr_src(1'b0);
    chk("R2 strap selected", 32'(freq_code), 19);
    wr_prog(1'b1);
    chk("R2 prog set", 32'(prog_en), 1);
    wr_prog(1'b0);
    wr_rev(1'b1);
    chk("R2 revert set", 32'(revert), 1);
    wr_tmo(4'd6);
    chk("R2 tmo set", 32'(tmo), 6);
    wr_tmo(4'd0);

    // random guarded changes
    for (int it = 0; it < 8; it++) begin
      int t; bit rv; int sw; bit use_prog;
      t = 1 + int'($urandom % 15);
      rv = 1'($urandom % 2);
      sw = int'($urandom % 32);
      use_prog = 1'($urandom % 2);
      strap = 5'($urandom % 32);
      wr_src(1'b0);
      wr_code(5'(sw));
      wr_tmo(4'(t));
      wr_rev(rv);
      if (use_prog) wr_prog(1'b1); else wr_code(5'(sw));
      expect_expiry(t, rv, sw, "rnd");
      expect_quiet(2 * CPS, "R7 disarmed after pulse");
      wr_tmo(4'(t));
      chk("R9 nonzero write keeps alarm", 32'(alarm), 1);
      wr_tmo(4'd0);
      chk("R9 zero write clears alarm", 32'(alarm), 0);
    end

    // R4 zero timeout: no recovery
    wr_code(5'd3);
    expect_quiet(20 * CPS, "R4 no pulse with zero timeout");

    // R5 cancel before expiry
    wr_tmo(4'd3);
    wr_src(1'b1);
    wr_code(5'd11);
    wait_n(2 * CPS);
    wr_tmo(4'd0);
    expect_quiet(4 * CPS, "R5 no pulse after cancel");
    chk("R5 source kept", 32'(src_sw), 1);
    chk("R5 code kept", 32'(freq_code), 11);
    chk("R5 alarm clear", 32'(alarm), 0);

    // R6 restart from full timeout
    wr_rev(1'b1);
    wr_tmo(4'd2);
    wr_code(5'd4);
    wait_n(CPS + 4);
    wr_code(5'd6);
    expect_expiry(2, 1'b1, 6, "R6 restart");
    wr_tmo(4'd0);

    // R9 nonzero write does not restart
    wr_tmo(4'd2);
    wr_code(5'd7);
    wait_n(9);
    wr_tmo(4'd5);
    wait_n(exp_delay(2) - 11);
    chk("R9 no restart before", 32'(pull), 0);
    wait_n(1);
    chk("R9 no restart expiry", 32'(pull), 1);
    wait_n(PW + 2);
    wr_tmo(4'd0);

    // R10 request during pulse ignored
    wr_tmo(4'd1);
    wr_code(5'd2);
    wait_n(CPS);
    chk("R10 in pulse", 32'(pull), 1);
    wr_code(5'd5);
    wait_n(PW + 2);
    expect_quiet(3 * CPS, "R10 no rearm from in-pulse request");
    wr_tmo(4'd0);

    // R11 disabling programmable mode is not a request
    wr_tmo(4'd1);
    wr_prog(1'b0);
    expect_quiet(3 * CPS, "R11 prog disable no pulse");
    wr_tmo(4'd0);

    h0 = checks;
    $display("TB_RESULT checks=%0d failures=%0d", h0, failures);
    $finish;
  end
endmodule